// File: doc/BRIEF.md
# Internal Data Memory Access Decoder

This block sits between the execution core of an 8-bit controller and its on-chip data storage. Every internal data access passes through it. The block turns the access into either a cycle on a 256-byte RAM port or a cycle on a special-function-register (SFR) bus. The SFR space shares the address range 80h–FFh with the upper half of RAM. The addressing mode of the access decides which of the two a high address reaches.

Four access kinds are handled:

- **Byte, direct:** a direct byte access.
- **Byte, indirect:** an indirect byte access. Stack traffic uses this kind as well.
- **Working register:** a working-register access. It carries a 3-bit register number, which is relocated by the two bank-select bits.
- **Bit:** a bit access. It carries an 8-bit bit address.

A bit read returns the chosen bit. A bit write is a two-cycle read-modify-write, and `busy` holds off new requests during its second cycle. Read results appear on `rd_data`, qualified by `rd_valid`, one cycle after the request is accepted. Both storage ports are synchronous and have one cycle of read latency.

Top module: `data_space_router`

## Requirements
- R1: A byte access with mode code 0 (direct) and an address of 00h–7Fh reaches the RAM port at that same address.
- R2: A direct access (mode 0) at 80h–FFh reaches only the SFR bus, with the full 8-bit address on `sfr_addr`. The RAM port and the SFR bus are never active in the same cycle.
- R3: A byte access with mode code 1 (indirect) reaches the RAM port at the given address over the whole range 00h–FFh, so 80h–FFh selects upper RAM.
- R4: With mode code 2 (working register), `req_addr[2:0]` is the register number r and `bank_sel` is the bank b. The RAM address used is b*8 + r, and `req_addr[7:3]` is ignored.
- R5: With mode code 3 (bit), a bit address a below 80h selects RAM byte 20h + a[6:3], bit a[2:0].
- R6: With mode code 3, a bit address a of 80h or above selects the SFR at a with its low three bits cleared, bit a[2:0].
- R7: A bit read returns the selected bit in `rd_data[0]`, with `rd_data[7:1]` zero.
- R8: A bit write stores `req_wbit` into only the selected bit and leaves the other seven bits unchanged. `busy` is high for exactly the one cycle after acceptance, and a request presented while `busy` is high is ignored.
- R9: `rd_valid` pulses for one cycle, exactly one cycle after a read (`req_write`=0) is accepted. A write never raises `rd_valid`.
- R10: An SFR address is implemented when its `SFR_PRESENT` bit (bit index addr-80h) is set. By default these are the addresses with addr[3]=0. A read of an unimplemented SFR returns `UNDEF_READ` (FFh by default), and a write to one never raises `sfr_we`.
- R11: After reset with no request pending, `busy`, `rd_valid`, `ram_en`, `sfr_re` and `sfr_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 working register, 3 bit |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte address, register number or bit address |
| bank_sel | input | 2 | Working-register bank |
| req_wdata | input | 8 | Byte to write |
| req_wbit | input | 1 | Bit value for a bit write |
| busy | output | 1 | Read-modify-write in progress; requests ignored |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after enable |
| sfr_re | output | 1 | SFR read strobe |
| sfr_we | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, one cycle after strobe |

## Verification
Most internal faults show up at the ports within two cycles of the access:

- **Misrouting:** a wrong target choice or address calculation shows up as a wrong byte returned by the next read of the affected location, because the bench keeps separate RAM and SFR models with different contents. Sending a high address to the wrong space is therefore visible on the first read that follows.
- **Stale pending state:** it shows up as a spurious or missing `rd_valid` in the cycle after acceptance.
- **Bad bit merge:** a bit merge that disturbs neighbouring bits is visible when the whole byte is read back.
- **Broken busy handling:** a request that slips through while `busy` is high corrupts a location the bench later reads.

// File: rtl/idm_pkg.sv
package idm_pkg;
   typedef enum logic [1:0] {
      ACC_DIRECT   = 2'd0,
      ACC_INDIRECT = 2'd1,
      ACC_REG      = 2'd2,
      ACC_BIT      = 2'd3
   } acc_mode_e;

   typedef enum logic [1:0] {
      TGT_RAM  = 2'd0,
      TGT_SFR  = 2'd1,
      TGT_NONE = 2'd2
   } tgt_e;

   typedef enum logic [1:0] {
      PK_IDLE   = 2'd0,
      PK_RDBYTE = 2'd1,
      PK_RDBIT  = 2'd2,
      PK_RMW    = 2'd3
   } pend_e;
endpackage

// File: rtl/idm_addr_map.sv
module idm_addr_map
   import idm_pkg::*;
#(
   parameter int BANK_W   = 2,
   parameter int REG_W    = 3,
   parameter int BIT_BASE = 32
) (
   input  acc_mode_e         mode,
   input  logic [7:0]        addr,
   input  logic [BANK_W-1:0] bank,
   output tgt_e              tgt,
   output logic [7:0]        byte_addr,
   output logic [2:0]        bit_pos
);
   localparam int PAD_W = 8 - BANK_W - REG_W;
   localparam logic [7:0] BASE8 = 8'(BIT_BASE);

   always_comb begin
      tgt       = TGT_RAM;
      byte_addr = addr;
      bit_pos   = addr[2:0];
      unique case (mode)
         ACC_DIRECT:   tgt = addr[7] ? TGT_SFR : TGT_RAM;
         ACC_INDIRECT: tgt = TGT_RAM;
         ACC_REG: begin
            if (PAD_W > 0)
               byte_addr = {{PAD_W{1'b0}}, bank, addr[REG_W-1:0]};
            else
               byte_addr = 8'({bank, addr[REG_W-1:0]});
         end
         ACC_BIT: begin
            if (addr[7]) begin
               tgt       = TGT_SFR;
               byte_addr = {addr[7:3], 3'b000};
            end else begin
               byte_addr = BASE8 + {4'b0000, addr[6:3]};
            end
         end
         default: tgt = TGT_NONE;
      endcase
   end
endmodule

// File: rtl/idm_sfr_gate.sv
module idm_sfr_gate
   import idm_pkg::*;
#(
   parameter logic [127:0] SFR_PRESENT = {8{16'h00FF}}
) (
   input  tgt_e       tgt_in,
   input  logic [6:0] idx,
   output tgt_e       tgt_out
);
   generate
      if (&SFR_PRESENT) begin : g_all_present
         assign tgt_out = tgt_in;
         logic unused_idx;
         assign unused_idx = ^idx;
      end else begin : g_sparse
         assign tgt_out = (tgt_in == TGT_SFR && !SFR_PRESENT[idx]) ? TGT_NONE : tgt_in;
      end
   endgenerate
endmodule

// File: rtl/idm_bit_ops.sv
module idm_bit_ops #(
   parameter int W = 8
) (
   input  logic [W-1:0]         byte_in,
   input  logic [$clog2(W)-1:0] pos,
   input  logic                 val,
   output logic                 bit_out,
   output logic [W-1:0]         merged
);
   localparam int PW = $clog2(W);

   assign bit_out = byte_in[pos];

   for (genvar i = 0; i < W; i++) begin : g_merge
      assign merged[i] = (pos == PW'(i)) ? val : byte_in[i];
   end
endmodule

// File: rtl/data_space_router.sv
module data_space_router
   import idm_pkg::*;
#(
   parameter int           BANK_W      = 2,
   parameter int           REG_W       = 3,
   parameter int           BIT_BASE    = 32,
   parameter logic [127:0] SFR_PRESENT = {8{16'h00FF}},
   parameter logic [7:0]   UNDEF_READ  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_mode,
   input  logic              req_write,
   input  logic [7:0]        req_addr,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic [7:0]        req_wdata,
   input  logic              req_wbit,
   output logic              busy,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              ram_en,
   output logic              ram_we,
   output logic [7:0]        ram_addr,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata,
   output logic              sfr_re,
   output logic              sfr_we,
   output logic [7:0]        sfr_addr,
   output logic [7:0]        sfr_wdata,
   input  logic [7:0]        sfr_rdata
);
   localparam int REG_SPAN = 1 << (BANK_W + REG_W);
   localparam int BIT_ROWS = 16;

   generate
      if (BANK_W + REG_W > 7) begin : g_bad_bank
         $error("register banks exceed the lower half of RAM");
      end
      if (BIT_BASE < REG_SPAN) begin : g_bad_overlap
         $error("bit area overlaps the register banks");
      end
      if (BIT_BASE + BIT_ROWS > 128) begin : g_bad_bitarea
         $error("bit area leaves the lower half of RAM");
      end
   endgenerate

   acc_mode_e mode;
   tgt_e      map_tgt, req_tgt;
   logic [7:0] map_addr;
   logic [2:0] map_pos;
   logic       accept;

   assign mode   = acc_mode_e'(req_mode);
   assign accept = req_valid && !busy;

   idm_addr_map #(.BANK_W(BANK_W), .REG_W(REG_W), .BIT_BASE(BIT_BASE)) u_map (
      .mode      (mode),
      .addr      (req_addr),
      .bank      (bank_sel),
      .tgt       (map_tgt),
      .byte_addr (map_addr),
      .bit_pos   (map_pos)
   );

   idm_sfr_gate #(.SFR_PRESENT(SFR_PRESENT)) u_gate (
      .tgt_in  (map_tgt),
      .idx     (map_addr[6:0]),
      .tgt_out (req_tgt)
   );

   pend_e      pend_kind;
   tgt_e       pend_tgt;
   logic [7:0] pend_addr;
   logic [2:0] pend_pos;
   logic       pend_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_kind <= PK_IDLE;
         pend_tgt  <= TGT_NONE;
         pend_addr <= '0;
         pend_pos  <= '0;
         pend_bit  <= 1'b0;
      end else begin
         if (accept) begin
            if (mode == ACC_BIT)
               pend_kind <= req_write ? PK_RMW : PK_RDBIT;
            else
               pend_kind <= req_write ? PK_IDLE : PK_RDBYTE;
            pend_tgt  <= req_tgt;
            pend_addr <= map_addr;
            pend_pos  <= map_pos;
            pend_bit  <= req_wbit;
         end else begin
            pend_kind <= PK_IDLE;
         end
      end
   end

   logic [7:0] src_byte, merged;
   logic       sel_bit;

   always_comb begin
      unique case (pend_tgt)
         TGT_RAM: src_byte = ram_rdata;
         TGT_SFR: src_byte = sfr_rdata;
         default: src_byte = UNDEF_READ;
      endcase
   end

   idm_bit_ops #(.W(8)) u_bits (
      .byte_in (src_byte),
      .pos     (pend_pos),
      .val     (pend_bit),
      .bit_out (sel_bit),
      .merged  (merged)
   );

   assign busy     = (pend_kind == PK_RMW);
   assign rd_valid = (pend_kind == PK_RDBYTE) || (pend_kind == PK_RDBIT);

   always_comb begin
      if (pend_kind == PK_RDBIT)       rd_data = {7'b0, sel_bit};
      else if (pend_kind == PK_RDBYTE) rd_data = src_byte;
      else                             rd_data = '0;
   end

   logic needs_read;
   assign needs_read = !req_write || (mode == ACC_BIT);

   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = '0;
      ram_wdata = '0;
      sfr_re    = 1'b0;
      sfr_we    = 1'b0;
      sfr_addr  = '0;
      sfr_wdata = '0;
      if (busy) begin
         if (pend_tgt == TGT_RAM) begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = pend_addr;
            ram_wdata = merged;
         end else if (pend_tgt == TGT_SFR) begin
            sfr_we    = 1'b1;
            sfr_addr  = pend_addr;
            sfr_wdata = merged;
         end
      end else if (accept) begin
         if (req_tgt == TGT_RAM) begin
            ram_en    = 1'b1;
            ram_we    = !needs_read;
            ram_addr  = map_addr;
            ram_wdata = req_wdata;
         end else if (req_tgt == TGT_SFR) begin
            sfr_re    = needs_read;
            sfr_we    = !needs_read;
            sfr_addr  = map_addr;
            sfr_wdata = req_wdata;
         end
      end
   end
endmodule

// File: rtl/idm_checker.sv
module idm_checker #(
   parameter logic [127:0] SFR_PRESENT = {8{16'h00FF}}
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_mode,
   input logic       req_write,
   input logic [7:0] req_addr,
   input logic       busy,
   input logic       rd_valid,
   input logic       ram_en,
   input logic [7:0] ram_addr,
   input logic       sfr_re,
   input logic       sfr_we,
   input logic [7:0] sfr_addr
);
   logic acc;
   assign acc = req_valid && !busy;

   assert_bitwrite_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_mode == 2'd3 && req_write |=> busy);

   assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   assert_read_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_write |=> rd_valid);

   assert_write_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_write |=> !rd_valid);

   assert_sfr_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_re || sfr_we) |-> sfr_addr[7]);

   assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_en && (sfr_re || sfr_we)));

   assert_indirect_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_mode == 2'd1 |-> ram_en && ram_addr == req_addr);

   assert_absent_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_we |-> SFR_PRESENT[sfr_addr[6:0]]);
endmodule

bind data_space_router idm_checker #(.SFR_PRESENT(SFR_PRESENT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_mode  (req_mode),
   .req_write (req_write),
   .req_addr  (req_addr),
   .busy      (busy),
   .rd_valid  (rd_valid),
   .ram_en    (ram_en),
   .ram_addr  (ram_addr),
   .sfr_re    (sfr_re),
   .sfr_we    (sfr_we),
   .sfr_addr  (sfr_addr)
);

// File: tb/data_space_router_test.sv
module data_space_router_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_mode = '0;
   logic       req_write = 1'b0;
   logic [7:0] req_addr = '0;
   logic [1:0] bank_sel = '0;
   logic [7:0] req_wdata = '0;
   logic       req_wbit = 1'b0;
   logic       busy, rd_valid, ram_en, ram_we, sfr_re, sfr_we;
   logic [7:0] rd_data, ram_addr, ram_wdata, sfr_addr, sfr_wdata;
   logic [7:0] ram_rdata = '0;
   logic [7:0] sfr_rdata = '0;

   always #5 clk = ~clk;

   data_space_router uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_write(req_write), .req_addr(req_addr), .bank_sel(bank_sel),
      .req_wdata(req_wdata), .req_wbit(req_wbit), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data), .ram_en(ram_en), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .sfr_re(sfr_re), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
   );

   logic [7:0] ram_m [256];
   logic [7:0] sfr_m [128];
   logic [7:0] ref_ram [256];
   logic [7:0] ref_sfr [128];

   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) ram_m[ram_addr] <= ram_wdata;
         else        ram_rdata <= ram_m[ram_addr];
      end
      if (sfr_we) sfr_m[sfr_addr[6:0]] <= sfr_wdata;
      if (sfr_re) sfr_rdata <= sfr_m[sfr_addr[6:0]];
   end

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Reference decode built from the requirements
   task automatic locate(input logic [1:0] m, input logic [7:0] a, input logic [1:0] b,
                         output int tgt, output logic [7:0] ba, output int pos);
      pos = int'(a[2:0]);
      ba  = a;
      tgt = 0;
      case (m)
         2'd0: tgt = a[7] ? 1 : 0;
         2'd1: tgt = 0;
         2'd2: ba = 8'(b) * 8'd8 + 8'(a[2:0]);
         default: begin
            if (a[7]) begin tgt = 1; ba = a & 8'hF8; end
            else      ba = 8'h20 + (a >> 3);
         end
      endcase
      if (tgt == 1 && ba[3]) tgt = 2;
   endtask

   task automatic access(input logic [1:0] m, input logic w, input logic [7:0] a,
                         input logic [1:0] b, input logic [7:0] wd, input logic wb,
                         input string tag);
      int tgt, pos;
      logic [7:0] ba, cur, nv;
      locate(m, a, b, tgt, ba, pos);
      cur = (tgt == 0) ? ref_ram[ba] : (tgt == 1) ? ref_sfr[ba[6:0]] : 8'hFF;
      @(negedge clk);
      while (busy) @(negedge clk);
      if (!w) begin
         exp_q.push_back((m == 2'd3) ? {7'b0, cur[pos]} : cur);
         tag_q.push_back(tag);
      end else begin
         nv = wd;
         if (m == 2'd3) begin nv = cur; nv[pos] = wb; end
         if (tgt == 0) ref_ram[ba] = nv;
         else if (tgt == 1) ref_sfr[ba[6:0]] = nv;
      end
      req_valid = 1'b1; req_mode = m; req_write = w; req_addr = a;
      bank_sel = b; req_wdata = wd; req_wbit = wb;
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   // Monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (rd_valid) begin
            if (exp_q.size() == 0) check("R9 spurious rd_valid", rd_data, 8'hxx);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
         if (sfr_re || sfr_we) check("R2 sfr address high", {7'b0, sfr_addr[7]}, 8'h01);
         if (sfr_we) check("R10 write to absent sfr", {7'b0, sfr_addr[3]}, 8'h00);
      end
   end

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      vectors++; miscompares++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [31:0] s;
      for (int i = 0; i < 256; i++) begin
         ram_m[i] = 8'(i * 37 + 5); ref_ram[i] = 8'(i * 37 + 5);
      end
      for (int i = 0; i < 128; i++) begin
         sfr_m[i] = 8'(i) ^ 8'h5A; ref_sfr[i] = 8'(i) ^ 8'h5A;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 idle outputs", {3'b0, busy, rd_valid, ram_en, sfr_re, sfr_we}, 8'h00);

      // R1 / R2 / R3: routing by mode
      access(2'd0, 1, 8'h90, 0, 8'h3C, 0, "R2");
      access(2'd1, 1, 8'h90, 0, 8'hA5, 0, "R3");
      access(2'd0, 0, 8'h90, 0, 0, 0, "R2 direct read of sfr");
      access(2'd1, 0, 8'h90, 0, 0, 0, "R3 indirect read of upper ram");
      access(2'd0, 1, 8'h45, 0, 8'h77, 0, "R1");
      access(2'd1, 0, 8'h45, 0, 0, 0, "R1 direct write seen indirectly");
      // R4: banked registers
      access(2'd2, 1, 8'h05, 2, 8'h11, 0, "R4");
      access(2'd1, 0, 8'h15, 0, 0, 0, "R4 bank2 reg5 at 15h");
      access(2'd2, 1, 8'hF7, 3, 8'h66, 0, "R4");
      access(2'd1, 0, 8'h1F, 0, 0, 0, "R4 upper bits ignored");
      access(2'd2, 0, 8'h03, 0, 0, 0, "R4 bank0 read");
      // R5 / R7 / R8: bit area in RAM
      access(2'd0, 1, 8'h21, 0, 8'h00, 0, "R5");
      access(2'd3, 1, 8'h0B, 0, 0, 1, "R8");
      access(2'd0, 0, 8'h21, 0, 0, 0, "R8 single bit set");
      access(2'd3, 0, 8'h0B, 0, 0, 0, "R7 bit read one");
      access(2'd3, 0, 8'h0C, 0, 0, 0, "R7 bit read zero");
      access(2'd3, 1, 8'h7F, 0, 0, 0, "R5");
      access(2'd0, 0, 8'h2F, 0, 0, 0, "R5 last bit row");
      // R6: SFR bits
      access(2'd3, 1, 8'h93, 0, 0, 0, "R6");
      access(2'd0, 0, 8'h90, 0, 0, 0, "R6 sfr bit cleared");
      access(2'd3, 0, 8'h95, 0, 0, 0, "R6 sfr bit read");
      // R10: unimplemented SFR
      access(2'd0, 1, 8'h98, 0, 8'h55, 0, "R10");
      access(2'd0, 0, 8'h98, 0, 0, 0, "R10 absent sfr read");
      access(2'd3, 0, 8'h9A, 0, 0, 0, "R10 absent sfr bit read");
      // R8: request during busy is ignored
      access(2'd3, 1, 8'h00, 0, 0, 1, "R8");
      @(negedge clk);
      check("R8 busy in second cycle", {7'b0, busy}, 8'h01);
      req_valid = 1'b1; req_mode = 2'd0; req_write = 1'b1; req_addr = 8'h40; req_wdata = 8'hEE;
      @(posedge clk);
      #1 req_valid = 1'b0;
      access(2'd1, 0, 8'h40, 0, 0, 0, "R8 request during busy ignored");
      access(2'd0, 0, 8'h20, 0, 0, 0, "R8 rmw result");
      // Pseudo-random mix
      s = 32'h1234_5678;
      for (int n = 0; n < 3000; n++) begin
         s ^= s << 13; s ^= s >> 17; s ^= s << 5;
         access(s[1:0], s[2], s[15:8], s[4:3], s[23:16], s[5], "R9 random mix");
      end
      repeat (3) @(negedge clk);
      check("R9 all reads answered", 8'(exp_q.size()), 8'h00);
      summary();
   end
endmodule